// File: doc/BRIEF.md
# APB Transfer Requester

This block is the requester side of an AMBA 3 APB bus. Local logic hands it simple read and write commands through a valid/ready request port. Each command carries an address, a direction and write data. The block runs the command as one APB transfer on a bus that four peripherals share. It drives a select line for one peripheral, the address, the direction, the write data and the enable strobe.

The peripheral may stretch a transfer by holding the ready input low. When a transfer completes, the response port gives a one-cycle valid pulse with the read data and the error flag. The block accepts a new command in the completing cycle. In that case the next transfer starts in the following cycle, so no idle cycle separates the two transfers.

Top module: `apb_requester`

## Requirements
- R1: While `rst_n` is low, all `psel` bits and `penable` are low. After reset, `req_ready` is high and `rsp_valid` is low until a command has been taken.
- R2: A command accepted at a clock edge (`req_valid` and `req_ready` both high) starts the setup cycle right after that edge. In the setup cycle, `penable` is low and exactly one `psel` bit is high: bit n, where n is the value of `req_addr[13:12]`. The bus also carries `paddr` equal to the command address and `pwrite` equal to the command direction (1 = write).
- R3: The setup cycle lasts exactly one clock cycle and is always followed by an access cycle with `penable` high.
- R4: `paddr`, `psel`, `pwrite` and `pwdata` do not change from the setup cycle through the last access cycle.
- R5: While `penable` is high and `pready` is low, the transfer stays in the access phase, and `rsp_valid` and `req_ready` stay low.
- R6: `req_ready` is high only when no transfer is in progress, or in an access cycle with `pready` high.
- R7: `rsp_valid` is high exactly in the cycle where `penable` and `pready` are both high. In that cycle, `rsp_err` equals `pslverr`. `rsp_rdata` equals `prdata` for a read and is zero for a write.
- R8: `pwdata` carries the command write data for a write and is zero for a read.
- R9: If a command is accepted in the completing access cycle, the next cycle is the setup cycle of the new command, with no idle cycle in between.
- R10: If no command is pending when a transfer completes, the next cycle has all `psel` bits and `penable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command can be taken this cycle |
| req_addr | input | 32 | Command address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Command write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data of the completed read |
| rsp_err | output | 1 | Error flag of the completed transfer |
| paddr | output | 32 | APB address |
| psel | output | 4 | One select line per peripheral |
| penable | output | 1 | High in the access phase |
| pwrite | output | 1 | APB direction |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | Read data from the selected peripheral |
| pready | input | 1 | Peripheral ready; low inserts a wait state |
| pslverr | input | 1 | Peripheral error; tie low if the peripheral has none |

## Verification
The bus signals of the setup cycle appear one edge after the command is accepted. The access cycle follows one edge later and repeats for each cycle that `pready` is held low. The response is combinational, so it is due in the same cycle as the `pready` high that completes the transfer. The idle or back-to-back setup state shows up one edge after that. The bench drives its inputs just after each rising edge and samples at the falling edge, so each check falls in the cycle where the expected value is due.

// File: rtl/apb_requester.sv
module apb_requester #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int NSEL    = 4,
  parameter int SEL_LSB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [AW-1:0] paddr,
  output logic [NSEL-1:0] psel,
  output logic          penable,
  output logic          pwrite,
  output logic [DW-1:0] pwdata,
  input  logic [DW-1:0] prdata,
  input  logic          pready,
  input  logic          pslverr
);
  localparam int SW = $clog2(NSEL);

  typedef enum logic [1:0] {IDLE, SETUP, ACCESS} phase_t;
  phase_t phase;

  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic          take, done;

  assign done      = (phase == ACCESS) && pready;
  assign req_ready = (phase == IDLE) || done;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      case (phase)
        IDLE:    if (take) phase <= SETUP;
        SETUP:   phase <= ACCESS;
        ACCESS:  if (pready) phase <= take ? SETUP : IDLE;
        default: phase <= IDLE;
      endcase
      if (take) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        wd_q   <= req_write ? req_wdata : '0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_sel
      assign psel[g] = (phase != IDLE) && (addr_q[SEL_LSB +: SW] == SW'(g));
    end
  endgenerate

  assign paddr     = addr_q;
  assign pwrite    = wr_q;
  assign pwdata    = wd_q;
  assign penable   = (phase == ACCESS);
  assign rsp_valid = done;
  assign rsp_rdata = wr_q ? '0 : prdata;
  assign rsp_err   = pslverr;
endmodule

module apb_requester_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NSEL = 4
) (
  input logic clk, rst_n, req_valid, req_ready, rsp_valid, penable, pwrite, pready,
  input logic [AW-1:0] paddr,
  input logic [NSEL-1:0] psel,
  input logic [DW-1:0] pwdata
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> (psel == '0) && !penable);
  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(psel));
  assert_setup_then_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel != '0) && !penable |=> penable);
  assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> $stable(paddr) && $stable(psel) && $stable(pwrite) && $stable(pwdata));
  assert_wait_extends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    penable && !pready |=> penable);
  assert_ready_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((psel == '0) && !penable) || (penable && pready));
  assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> penable && pready);
  assert_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    penable && pready && req_valid |=> (psel != '0) && !penable);
  assert_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    penable && pready && !req_valid |=> (psel == '0) && !penable);
endmodule

bind apb_requester apb_requester_chk #(.AW(AW), .DW(DW), .NSEL(NSEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .penable(penable), .pwrite(pwrite), .pready(pready),
  .paddr(paddr), .psel(psel), .pwdata(pwdata));

// File: tb/apb_requester_test.sv
`timescale 1ns/1ps
module apb_requester_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, pready = 0, pslverr = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err, penable, pwrite;
  logic [31:0] rsp_rdata, paddr, pwdata, prdata;
  logic [3:0] psel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign prdata = ~paddr;

  apb_requester uut (.*);

  // addr, write, wdata, waits, err
  localparam logic [69:0] VEC [0:5] = '{
    {32'h0000_0010, 1'b1, 32'hDEAD_BEEF, 4'd0, 1'b0},
    {32'h0000_1024, 1'b0, 32'h1111_2222, 4'd0, 1'b0},
    {32'h0000_2F00, 1'b1, 32'h0BAD_CAFE, 4'd3, 1'b0},
    {32'h8000_3004, 1'b0, 32'h0,         4'd2, 1'b1},
    {32'h0000_3FFC, 1'b1, 32'h5A5A_A5A5, 4'd1, 1'b1},
    {32'h1234_0ABC, 1'b0, 32'h0,         4'd5, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic check_setup(input logic [31:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    chk(psel == 4'b1 << a[13:12], "R2 psel", {28'b0, psel}, {28'b0, 4'b1 << a[13:12]});
    chk(!penable, "R2 penable low in setup", {31'b0, penable}, 0);
    chk(paddr == a && pwrite == w, "R2 paddr", paddr, a);
    chk(pwdata == (w ? d : 0), "R8 pwdata", pwdata, w ? d : 0);
  endtask

  task automatic finish_access(input logic [31:0] a, input logic w, input logic [31:0] d,
                               input int waits, input logic err);
    @(posedge clk); #1;
    for (int k = 0; k < waits; k++) begin
      pready = 0;
      @(negedge clk);
      chk(penable && !rsp_valid && !req_ready, "R5 wait state", {29'b0, penable, rsp_valid, req_ready}, 32'h4);
      chk(paddr == a && psel == 4'b1 << a[13:12] && pwdata == (w ? d : 0), "R4 stable", paddr, a);
      @(posedge clk); #1;
    end
    pready = 1; pslverr = err;
    @(negedge clk);
    chk(penable, "R3 access", {31'b0, penable}, 1);
    chk(rsp_valid && req_ready, "R7 rsp_valid/R6 ready", {30'b0, rsp_valid, req_ready}, 3);
    chk(rsp_err == err, "R7 rsp_err", {31'b0, rsp_err}, {31'b0, err});
    chk(rsp_rdata == (w ? 0 : ~a), "R7 rsp_rdata", rsp_rdata, w ? 0 : ~a);
  endtask

  task automatic run(input logic [31:0] a, input logic w, input logic [31:0] d,
                     input int waits, input logic err);
    issue(a, w, d);
    check_setup(a, w, d);
    finish_access(a, w, d, waits, err);
    @(posedge clk); #1; pready = 0; pslverr = 0;
    @(negedge clk);
    chk(psel == 0 && !penable && req_ready && !rsp_valid, "R10 idle after", {28'b0, psel}, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    chk(psel == 0 && !penable, "R1 in reset", {28'b0, psel}, 0);
    #20; rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && psel == 0, "R1 after reset", {31'b0, req_ready}, 1);

    foreach (VEC[i]) begin
      logic [69:0] v;
      v = VEC[i];
      run(v[69:38], v[37], v[36:5], int'(v[4:1]), v[0]);
    end

    // R9 back-to-back
    issue(32'h0000_1100, 1'b1, 32'hCAFE_0001);
    check_setup(32'h0000_1100, 1'b1, 32'hCAFE_0001);
    @(posedge clk); #1;
    pready = 1; req_valid = 1; req_addr = 32'h0000_3200; req_write = 0;
    @(negedge clk);
    chk(req_ready && rsp_valid, "R9 take in completing cycle", {30'b0, req_ready, rsp_valid}, 3);
    @(posedge clk); #1; req_valid = 0; pready = 0;
    @(negedge clk);
    chk(psel == 4'b1000 && !penable && paddr == 32'h3200, "R9 no idle gap", {28'b0, psel}, 8);
    chk(!req_ready, "R6 not ready in setup", {31'b0, req_ready}, 0);
    finish_access(32'h0000_3200, 1'b0, 0, 1, 0);
    @(posedge clk); #1; pready = 0;
    @(negedge clk);
    chk(psel == 0 && !penable, "R10 idle after chain", {28'b0, psel}, 0);

    // R1 reset mid-transfer
    issue(32'h0000_2000, 1'b0, 0);
    @(posedge clk); #1;
    rst_n = 0;
    #1;
    chk(psel == 0 && !penable, "R1 reset mid access", {27'b0, penable, psel}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(req_ready && psel == 0, "R1 idle after reset", {31'b0, req_ready}, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule